// File: doc/BRIEF.md
# Prioritised Interrupt Level Gate

This block sits between a set of level-sensitive interrupt request lines and a processor's trap logic. Each of fifteen request lines stands for one priority level from 1 to 15, and level 15 is the most urgent. Every cycle the block finds the most urgent level that is pending. It compares that level against a programmable threshold, the processor interrupt level, and against a global interrupt enable. When both allow it, the block raises a registered one-cycle accept strobe and reports the level as a trap type.

After a delivery the block waits for an acknowledge before it delivers again. A requester keeps its line high until software services it. A request that is still high after the acknowledge is therefore offered again, while a line that has dropped is simply no longer seen.

Top module: `irq_level_gate`

## Requirements
- R1: While `rst_n` is low and on the first cycle after reset, `take` is 0 and `trap_type` is 0x00.
- R2: Bit i of `irq_req` requests level i+1. When several lines are high, the highest-numbered level is the one delivered.
- R3: The candidate level is delivered only if it is strictly greater than `pil`. A `pil` of 0 lets every level from 1 to 15 through, and a `pil` of 15 blocks them all.
- R4: While `int_en` is 0, no delivery is made, whatever the requests are.
- R5: `take` is registered. It goes high in the cycle after the edge at which a deliverable request, `pil` and `int_en` are sampled with the gate idle, and it stays high for exactly one cycle.
- R6: After a delivery, no further `take` is raised until `ack` has been sampled high. It may be sampled high in the `take` cycle or in any later cycle. An `ack` sampled while the gate is idle has no effect.
- R7: `trap_type` equals 0x40 plus the delivered level. It is loaded at the `take` edge and holds its value until the next delivery.
- R8: A request line that is still high after the acknowledge is delivered again. Requests are not latched, so a line that falls before it is delivered is never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 15 | Level-sensitive requests, bit i = level i+1 |
| pil | input | 4 | Processor interrupt level threshold |
| int_en | input | 1 | Global interrupt enable |
| ack | input | 1 | Acknowledge of the last delivery |
| take | output | 1 | One-cycle accept strobe |
| trap_type | output | 8 | 0x40 plus the accepted level |

## Verification
The hardest case to reach from the ports is an acknowledge that arrives in the same cycle as the strobe, while a request is still held and the threshold moves at the same moment. In that case the next delivery must come exactly two cycles after the first, and it must respect the new threshold. The bench reaches this case with a long random phase in which `ack` is often high and `pil` and `int_en` change every cycle. A behavioural model, compared on every clock, catches any cycle slip. Directed phases before the random one pin down the threshold edge cases: equal to the level, one below it, 0 and 15.

// File: rtl/irq_level_gate.sv
module irq_level_gate #(
  parameter int NLVL    = 16,
  parameter int TTW     = 8,
  parameter int TT_BASE = 'h40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLVL-2:0]          irq_req,
  input  logic [$clog2(NLVL)-1:0]  pil,
  input  logic                     int_en,
  input  logic                     ack,
  output logic                     take,
  output logic [TTW-1:0]           trap_type
);
  localparam int LW = $clog2(NLVL);
  localparam logic [TTW-1:0] BASE = TTW'(TT_BASE);

  logic [LW-1:0] top_lvl;
  logic          elig;
  logic          busy;

  always_comb begin
    top_lvl = '0;
    for (int i = 1; i < NLVL; i++)
      if (irq_req[i-1]) top_lvl = LW'(i);
  end

  assign elig = int_en && (top_lvl > pil);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      take      <= 1'b0;
      trap_type <= '0;
    end else begin
      take <= !busy && elig;
      if (!busy && elig) trap_type <= BASE + TTW'(top_lvl);
      if (busy && ack)        busy <= 1'b0;
      else if (!busy && elig) busy <= 1'b1;
    end
  end

  logic [TTW-1:0] acc_lvl;
  assign acc_lvl = trap_type - BASE;

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (acc_lvl >= TTW'(1) && acc_lvl <= TTW'(NLVL-1)));
  p_above_pil_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (acc_lvl > TTW'($past(pil))));
  p_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(int_en));
  p_highest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (($past(irq_req) >> acc_lvl) == '0));
  p_wait_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack) |=> !take);
  p_hold_tt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> $stable(trap_type));
endmodule

// File: tb/irq_level_gate_tb.sv
module irq_level_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] irq_req = '0;
  logic [3:0]  pil = '0;
  logic        int_en = 1'b0;
  logic        ack = 1'b0;
  logic        take;
  logic [7:0]  trap_type;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  int m_busy = 0, m_take = 0, m_tt = 0;

  always #10 clk = ~clk;

  irq_level_gate u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .pil(pil),
    .int_en(int_en), .ack(ack), .take(take), .trap_type(trap_type)
  );

  function automatic int best_level(input logic [14:0] r);
    int b = 0;
    for (int i = 0; i < 15; i++) if (r[i]) b = i + 1;
    return b;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_take = 0; m_tt = 0;
    end else begin
      int b;
      int ok;
      b = best_level(irq_req);
      ok = (int_en && b > int'(pil)) ? 1 : 0;
      m_take = (m_busy == 0 && ok == 1) ? 1 : 0;
      if (m_take == 1) m_tt = 'h40 + b;
      if (m_busy == 1 && ack) m_busy = 0;
      else if (m_busy == 0 && ok == 1) m_busy = 1;
    end
  end

  always @(negedge clk) begin
    if (cyc > 0) begin
      compared++;
      if (int'(take) != m_take) begin
        mismatched++;
        $display("FAIL R5 cycle %0d take act=%0d exp=%0d", cyc, take, m_take);
      end
      compared++;
      if (int'(trap_type) != m_tt) begin
        mismatched++;
        $display("FAIL R7 cycle %0d trap_type act=%0h exp=%0h", cyc, trap_type, m_tt);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_takes(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (take) cnt++;
    end
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    int cnt;
    int v;
    cycles(3);
    chk(take == 1'b0, "R1 take in reset", take, 0);
    chk(trap_type == 8'h00, "R1 trap_type in reset", trap_type, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(take == 1'b0 && trap_type == 8'h00, "R1 after reset", trap_type, 0);

    irq_req = 15'b000_1000_0001_0000; int_en = 1'b1; pil = 4'd0;
    @(negedge clk);
    chk(take == 1'b1, "R5 take one cycle after request", take, 1);
    chk(trap_type == 8'h4C, "R2 highest of levels 5 and 12", trap_type, 'h4C);
    @(negedge clk);
    chk(take == 1'b0, "R5 take lasts one cycle", take, 0);
    count_takes(6, cnt);
    chk(cnt == 0, "R6 no delivery before ack", cnt, 0);
    chk(trap_type == 8'h4C, "R7 trap_type held", trap_type, 'h4C);

    do_ack();
    count_takes(3, cnt);
    chk(cnt == 1 && trap_type == 8'h4C, "R8 held request redelivered", trap_type, 'h4C);
    do_ack();

    irq_req[11] = 1'b0; pil = 4'd5;
    count_takes(5, cnt);
    chk(cnt == 0, "R3 level equal to pil ignored", cnt, 0);
    pil = 4'd4;
    count_takes(3, cnt);
    chk(cnt == 1 && trap_type == 8'h45, "R3 level above pil delivered", trap_type, 'h45);
    do_ack();

    irq_req = 15'h7FFF; pil = 4'd15;
    count_takes(5, cnt);
    chk(cnt == 0, "R3 pil 15 blocks all", cnt, 0);
    pil = 4'd0; irq_req = 15'h0001;
    count_takes(3, cnt);
    chk(cnt == 1 && trap_type == 8'h41, "R3 pil 0 passes level 1", trap_type, 'h41);
    do_ack();

    int_en = 1'b0; irq_req = 15'h4000;
    count_takes(6, cnt);
    chk(cnt == 0, "R4 disabled blocks", cnt, 0);
    chk(trap_type == 8'h41, "R7 held while disabled", trap_type, 'h41);

    irq_req = 15'h0; ack = 1'b1;
    cycles(2);
    ack = 1'b0; irq_req = 15'h0100; int_en = 1'b1;
    @(negedge clk);
    chk(take == 1'b1 && trap_type == 8'h49, "R6 idle ack has no effect", trap_type, 'h49);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(take == 1'b0, "R5 no take right after ack in take cycle", take, 0);
    @(negedge clk);
    chk(take == 1'b1, "R8 redelivery two cycles after first", take, 1);
    do_ack();

    irq_req = 15'h0; cycles(2);
    irq_req = 15'h0040; @(negedge clk); irq_req = 15'h0;
    chk(take == 1'b1 && trap_type == 8'h47, "R8 short pulse caught when idle", trap_type, 'h47);
    count_takes(3, cnt);
    do_ack();
    irq_req = 15'h0; pil = 4'd15; irq_req = 15'h0002; @(negedge clk);
    irq_req = 15'h0; pil = 4'd0;
    count_takes(4, cnt);
    chk(cnt == 0, "R8 dropped request never reported", cnt, 0);

    for (int k = 0; k < 3000; k++) begin
      v = $urandom_range(0, 9);
      irq_req = (v < 3) ? 15'h0 : 15'($urandom());
      pil = 4'($urandom_range(0, 15));
      int_en = ($urandom_range(0, 5) != 0);
      ack = ($urandom_range(0, 2) == 0);
      @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule